// File: doc/BRIEF.md
# FIFO Threshold Offset Controller

This block keeps the two threshold offsets of a dual-clock FIFO and produces its almost-empty and almost-full indications. The empty offset `n` sets how few stored words count as "almost empty". The full offset `m` sets how close to capacity the fill must come before "almost full" is raised. The storage array and its pointer logic sit outside. The block sees only the two pointers, Gray coded, each in its own clock domain. It brings each pointer into the other domain through a synchroniser and forms the fill level locally.

Master reset is synchronous and must span at least one edge of each clock. While it is held, the `load_en` pin acts as a strap. High selects a default of 1023 for both offsets and word-wide (parallel) programming. Low selects 127 for both offsets and bit-serial programming. After reset, `load_en` qualifies offset access. In serial mode, bits enter through `ser_in`. In parallel mode, words are written from `din` on the write clock. In either mode, words are read back on `dout` on the read clock. Partial reset restarts all sequencing and clears `dout`. It keeps the offsets and the programming method.

A write-side state machine runs the programming. CFG_STRAP is held through master reset. It moves to CFG_PAR when the strap was high and to CFG_SER_LOAD when it was low. CFG_SER_LOAD moves to CFG_SER_DONE when the last register bit is taken. CFG_SER_DONE returns to CFG_SER_LOAD on partial reset. CFG_PAR stays until the next master reset, and master reset forces CFG_STRAP from any state.

Top module: `ofs_flag_unit`

## Requirements
- R1: Master reset clears `dout`. It sets both offsets to 1023 with parallel programming when `load_en` is high at the last write-clock edge of reset, and to 127 with serial programming when it is low. Afterwards `aempty_n` is 0 and `afull_n` is 1 for equal pointers.
- R2: In serial mode, each write-clock edge with `load_en` and `ser_en` high stores `ser_in` into the next bit. Bits fill the empty offset from bit 0 to bit 11, then the full offset from bit 0 to bit 11.
- R3: After 24 serial bits have been taken, further serial bits change neither offset until a partial or master reset.
- R4: In parallel mode, each write-clock edge with `load_en` and `wr_en` high writes `din` into the next slot. Slot 0 is empty offset bits 8:0. Slot 1 is empty offset bits 11:9, taken from `din[2:0]`. Slots 2 and 3 hold the full offset in the same way. After slot 3 the sequence returns to slot 0.
- R5: Each read-clock edge with `load_en` and `rd_en` high loads the next slot onto `dout`, in the slot order of R4. Unused upper bits read as zero.
- R6: `afull_n` is low exactly when the write-domain fill exceeds 4096 minus the full offset. The fill is the write pointer minus the synchronised read pointer, modulo 8192.
- R7: `aempty_n` is low exactly when the read-domain fill is below the empty offset. The fill is the synchronised write pointer minus the read pointer, modulo 8192.
- R8: Partial reset keeps both offsets and the programming method. It clears `dout` and restarts the serial bit position, the write slot and the read slot at zero.
- R9: In parallel mode, serial loading has no effect on the offsets. In serial mode, parallel writes have no effect on the offsets.
- R10: `wr_en` or `rd_en` without `load_en` changes neither the offsets nor `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, sampled by both clocks |
| prst | input | 1 | Partial reset, active high, sampled by both clocks |
| load_en | input | 1 | Offset access qualifier; strap during master reset |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset data |
| wr_en | input | 1 | Write qualifier for parallel offset writes |
| rd_en | input | 1 | Read qualifier for offset readback |
| din | input | 9 | Parallel offset word |
| dout | output | 9 | Offset readback word |
| wr_ptr_g | input | 13 | FIFO write pointer, Gray coded, write-clock domain |
| rd_ptr_g | input | 13 | FIFO read pointer, Gray coded, read-clock domain |
| afull_n | output | 1 | Almost-full indication, active low, write-clock domain |
| aempty_n | output | 1 | Almost-empty indication, active low, read-clock domain |

## Verification
The hardest states to reach are those where a sequence position and a stored offset disagree. One is a serial stream that runs past the 24th bit. Another is a parallel or readback sequence cut off in mid-offset by partial reset. The stimulus overfeeds the serial stream with ones. It writes a single parallel word before a partial reset, then writes a full set of words that only read back correctly if the slot restarted. It reads one slot before a partial reset so that the next readback shows whether the read slot was reset. The thresholds are hit at exactly the boundary fill, once with pointers that wrap past the top of the 13-bit range.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        CFG_STRAP    = 2'd0,
        CFG_SER_LOAD = 2'd1,
        CFG_SER_DONE = 2'd2,
        CFG_PAR      = 2'd3
    } cfg_state_e;

    // number of bus words needed to carry one offset
    function automatic int words_per_ofs(int ofs_w, int bus_w);
        return (ofs_w + bus_w - 1) / bus_w;
    endfunction

endpackage

// File: rtl/ofs_gray_sync.sv
module ofs_gray_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] g_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= g_in;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) bin_out[i] = ^(pipe[STAGES-1] >> i);
    end

endmodule

// File: rtl/ofs_cfg_wr.sv
module ofs_cfg_wr
    import ofs_pkg::*;
#(
    parameter int DW     = 9,
    parameter int OW     = 12,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            load_en,
    input  logic            ser_en,
    input  logic            ser_in,
    input  logic            wr_en,
    input  logic [DW-1:0]   din,
    output logic [2*OW-1:0] ofs_cat
);

    localparam int NW   = words_per_ofs(OW, DW);
    localparam int NS   = 2 * NW;
    localparam int SW   = (NS > 1) ? $clog2(NS) : 1;
    localparam int TOT  = 2 * OW;
    localparam int BW   = $clog2(TOT + 1);
    localparam int PADW = NW * DW;
    localparam logic [OW-1:0] DLO = OW'(DEF_LO);
    localparam logic [OW-1:0] DHI = OW'(DEF_HI);

    cfg_state_e      state, state_nx;
    logic            strap_par;
    logic [BW-1:0]   bit_pos;
    logic [SW-1:0]   wslot;
    logic            ser_take, par_take;
    logic [2*PADW-1:0] pad_new;

    // state register
    always_ff @(posedge clk) begin
        if (mrst) state <= CFG_STRAP;
        else      state <= state_nx;
    end

    // strap capture while master reset is held
    always_ff @(posedge clk) begin
        if (mrst) strap_par <= load_en;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CFG_STRAP:    state_nx = strap_par ? CFG_PAR : CFG_SER_LOAD;
            CFG_SER_LOAD: if (!prst && load_en && ser_en && bit_pos == BW'(TOT-1))
                              state_nx = CFG_SER_DONE;
            CFG_SER_DONE: if (prst) state_nx = CFG_SER_LOAD;
            CFG_PAR:      state_nx = CFG_PAR;
        endcase
    end

    // output decode per state
    always_comb begin
        ser_take = 1'b0;
        par_take = 1'b0;
        unique case (state)
            CFG_SER_LOAD: ser_take = load_en && ser_en && !prst;
            CFG_PAR:      par_take = load_en && wr_en && !prst;
            default: ;
        endcase
    end

    // padded image with the addressed slot replaced by the bus word
    always_comb begin
        pad_new = '0;
        pad_new[0 +: OW]    = ofs_cat[0 +: OW];
        pad_new[PADW +: OW] = ofs_cat[OW +: OW];
        pad_new[wslot*DW +: DW] = din;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            ofs_cat <= load_en ? {DHI, DHI} : {DLO, DLO};
            bit_pos <= '0;
            wslot   <= '0;
        end else if (prst) begin
            bit_pos <= '0;
            wslot   <= '0;
        end else begin
            if (ser_take) begin
                ofs_cat[bit_pos] <= ser_in;
                bit_pos          <= bit_pos + 1'b1;
            end
            if (par_take) begin
                ofs_cat <= {pad_new[PADW +: OW], pad_new[0 +: OW]};
                wslot   <= (wslot == SW'(NS-1)) ? '0 : wslot + 1'b1;
            end
        end
    end

    // R1
    strap_enter_chk: assert property (@(posedge clk) disable iff (mrst)
        $fell(mrst) |-> state == CFG_STRAP);

    // R3
    ser_tail_ignored_chk: assert property (@(posedge clk) disable iff (mrst)
        (state == CFG_SER_DONE) |=> $stable(ofs_cat));

    // R8
    prst_keeps_ofs_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> $stable(ofs_cat));

    // R9
    par_ignores_ser_chk: assert property (@(posedge clk) disable iff (mrst)
        (state == CFG_PAR && !(load_en && wr_en)) |=> $stable(ofs_cat));

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int DW = 9,
    parameter int OW = 12
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            load_en,
    input  logic            rd_en,
    input  logic [2*OW-1:0] ofs_cat,
    output logic [DW-1:0]   dout
);

    localparam int NW   = words_per_ofs(OW, DW);
    localparam int NS   = 2 * NW;
    localparam int SW   = (NS > 1) ? $clog2(NS) : 1;
    localparam int PADW = NW * DW;

    logic [SW-1:0]     rslot;
    logic [2*PADW-1:0] pad;
    logic [DW-1:0]     word;

    always_comb begin
        pad = '0;
        pad[0 +: OW]    = ofs_cat[0 +: OW];
        pad[PADW +: OW] = ofs_cat[OW +: OW];
        word = pad[rslot*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            rslot <= '0;
            dout  <= '0;
        end else if (load_en && rd_en) begin
            dout  <= word;
            rslot <= (rslot == SW'(NS-1)) ? '0 : rslot + 1'b1;
        end
    end

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        (!(load_en && rd_en) && !prst) |=> $stable(dout));

    // R8
    prst_clear_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> dout == '0);

endmodule

// File: rtl/ofs_level_flag.sv
module ofs_level_flag #(
    parameter int PW      = 13,
    parameter int OW      = 12,
    parameter int DEPTH   = 4096,
    parameter bit IS_FULL = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_bin,
    input  logic [PW-1:0] rd_bin,
    input  logic [OW-1:0] ofs,
    output logic          flag_n
);

    logic [PW-1:0] fill;
    logic          hit;

    assign fill = wr_bin - rd_bin;

    generate
        if (IS_FULL) begin : g_full
            localparam logic [PW:0] DEP = (PW+1)'(DEPTH);
            logic [PW:0] lim;
            assign lim = DEP - {{(PW+1-OW){1'b0}}, ofs};
            assign hit = {1'b0, fill} > lim;
        end else begin : g_empty
            assign hit = fill < {{(PW-OW){1'b0}}, ofs};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flag_n <= IS_FULL;
        else     flag_n <= !hit;
    end

endmodule

// File: rtl/ofs_flag_unit.sv
module ofs_flag_unit #(
    parameter int DW          = 9,
    parameter int AW          = 12,
    parameter int DEF_LO      = 127,
    parameter int DEF_HI      = 1023,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             load_en,
    input  logic             ser_en,
    input  logic             ser_in,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    input  logic [AW:0]      wr_ptr_g,
    input  logic [AW:0]      rd_ptr_g,
    output logic             afull_n,
    output logic             aempty_n
);

    localparam int PW    = AW + 1;
    localparam int OW    = AW;
    localparam int DEPTH = 1 << AW;

    logic [2*OW-1:0] ofs_cat;
    logic [PW-1:0]   w_own, w_far, r_own, r_far;

    ofs_cfg_wr #(.DW(DW), .OW(OW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_cfg (
        .clk(wclk), .mrst(mrst), .prst(prst), .load_en(load_en),
        .ser_en(ser_en), .ser_in(ser_in), .wr_en(wr_en), .din(din),
        .ofs_cat(ofs_cat)
    );

    ofs_rd_port #(.DW(DW), .OW(OW)) u_rd (
        .clk(rclk), .mrst(mrst), .prst(prst), .load_en(load_en),
        .rd_en(rd_en), .ofs_cat(ofs_cat), .dout(dout)
    );

    // write-clock side: own pointer retimed, read pointer synchronised
    ofs_gray_sync #(.W(PW), .STAGES(1)) u_w_own (
        .clk(wclk), .rst(mrst), .g_in(wr_ptr_g), .bin_out(w_own));
    ofs_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w_far (
        .clk(wclk), .rst(mrst), .g_in(rd_ptr_g), .bin_out(w_far));

    // read-clock side: own pointer retimed, write pointer synchronised
    ofs_gray_sync #(.W(PW), .STAGES(1)) u_r_own (
        .clk(rclk), .rst(mrst), .g_in(rd_ptr_g), .bin_out(r_own));
    ofs_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r_far (
        .clk(rclk), .rst(mrst), .g_in(wr_ptr_g), .bin_out(r_far));

    ofs_level_flag #(.PW(PW), .OW(OW), .DEPTH(DEPTH), .IS_FULL(1'b1)) u_afull (
        .clk(wclk), .rst(mrst), .wr_bin(w_own), .rd_bin(w_far),
        .ofs(ofs_cat[OW +: OW]), .flag_n(afull_n));

    ofs_level_flag #(.PW(PW), .OW(OW), .DEPTH(DEPTH), .IS_FULL(1'b0)) u_aempty (
        .clk(rclk), .rst(mrst), .wr_bin(r_far), .rd_bin(r_own),
        .ofs(ofs_cat[0 +: OW]), .flag_n(aempty_n));

    // R6
    afull_reset_chk: assert property (@(posedge wclk) disable iff (mrst)
        $fell(mrst) |-> afull_n);

    // R7
    aempty_reset_chk: assert property (@(posedge rclk) disable iff (mrst)
        $fell(mrst) |-> !aempty_n);

endmodule

// File: tb/ofs_flag_unit_tb.sv
module ofs_flag_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD + 4;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst = 1'b1, prst = 1'b0;
    logic load_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  din = '0;
    logic [8:0]  dout;
    logic [12:0] wr_ptr_g = '0, rd_ptr_g = '0;
    logic afull_n, aempty_n;

    int n_cmp = 0, n_bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    bit         rd_taken = 1'b0;

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RD_PERIOD/2)  rclk = ~rclk;

    ofs_flag_unit u_dut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
        .load_en(load_en), .ser_en(ser_en), .ser_in(ser_in),
        .wr_en(wr_en), .rd_en(rd_en), .din(din), .dout(dout),
        .wr_ptr_g(wr_ptr_g), .rd_ptr_g(rd_ptr_g),
        .afull_n(afull_n), .aempty_n(aempty_n)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] gray(int v);
        logic [12:0] b = v[12:0];
        return b ^ (b >> 1);
    endfunction

    // scoreboard monitor: compares each readback result
    always @(negedge rclk) begin
        if (rd_taken) begin
            rd_taken = 1'b0;
            if (exp_q.size() == 0) check("R5 unexpected readback", 1, 0);
            else check(tag_q.pop_front(), int'(dout), int'(exp_q.pop_front()));
        end
    end

    task automatic do_mrst(bit strap);
        @(negedge wclk); mrst = 1'b1; load_en = strap;
        repeat (3) @(negedge rclk);
        repeat (2) @(negedge wclk);
        mrst = 1'b0; load_en = 1'b0;
        repeat (3) @(negedge wclk);
        repeat (2) @(negedge rclk);
    endtask

    task automatic do_prst();
        @(negedge wclk); prst = 1'b1;
        repeat (2) @(negedge rclk);
        @(negedge wclk); prst = 1'b0;
        repeat (2) @(negedge rclk);
    endtask

    task automatic ser_load(logic [23:0] bits, int n);
        @(negedge wclk); load_en = 1'b1; ser_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            ser_in = (i < 24) ? bits[i] : 1'b1;
            @(negedge wclk);
        end
        load_en = 1'b0; ser_en = 1'b0;
    endtask

    task automatic par_write(logic [8:0] w);
        @(negedge wclk); load_en = 1'b1; wr_en = 1'b1; din = w;
        @(negedge wclk); load_en = 1'b0; wr_en = 1'b0;
    endtask

    // driver: pushes the expected word and performs one readback
    task automatic rb(logic [8:0] v, string tag);
        @(negedge rclk); load_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(v); tag_q.push_back(tag);
        @(posedge rclk); rd_taken = 1'b1;
        @(negedge rclk); load_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic rb_all(int e, int f, string tag);
        rb(e[8:0], tag);
        rb({6'b0, e[11:9]}, tag);
        rb(f[8:0], tag);
        rb({6'b0, f[11:9]}, tag);
    endtask

    task automatic set_ptrs(int w, int r);
        @(negedge wclk); wr_ptr_g = gray(w);
        @(negedge rclk); rd_ptr_g = gray(r);
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic flags(int w, int r, int n, int m);
        int cnt;
        set_ptrs(w, r);
        cnt = (w - r) & 8191;
        check("R6 almost-full", int'(afull_n), (cnt > 4096 - m) ? 0 : 1);
        check("R7 almost-empty", int'(aempty_n), (cnt < n) ? 0 : 1);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1");
        summary();
    end

    initial begin
        // serial strap, default 127
        do_mrst(1'b0);
        check("R1 dout after reset", int'(dout), 0);
        check("R1 afull_n after reset", int'(afull_n), 1);
        check("R1 aempty_n after reset", int'(aempty_n), 0);
        rb_all(127, 127, "R1 serial default");
        flags(3969, 0, 127, 127);
        flags(3970, 0, 127, 127);
        flags(4126, 4000, 127, 127);
        flags(86, 8150, 127, 127);
        // parallel write in serial mode is ignored
        par_write(9'h055);
        rb_all(127, 127, "R9 par write in serial mode");

        // serial load with 5 surplus bits
        ser_load({12'd2000, 12'd300}, 29);
        rb_all(300, 2000, "R2 serial load");
        ser_load(24'h0, 8);
        rb_all(300, 2000, "R3 surplus serial bits");
        flags(2096, 0, 300, 2000);
        flags(2097, 0, 300, 2000);
        flags(4299, 4000, 300, 2000);
        flags(4300, 4000, 300, 2000);
        flags(1905, 8000, 300, 2000);

        // partial reset mid readback
        rb(9'd300, "R5 first slot");
        do_prst();
        check("R8 dout cleared", int'(dout), 0);
        rb_all(300, 2000, "R8 offsets kept, read slot restarted");
        ser_load({12'd9, 12'd5}, 24);
        rb_all(5, 9, "R8 serial restart");

        // enables without load_en
        rb(9'd5, "R5 slot0");
        @(negedge rclk); rd_en = 1'b1;
        repeat (3) @(negedge rclk);
        rd_en = 1'b0;
        check("R10 dout hold", int'(dout), 5);
        rb(9'd0, "R5 slot1"); rb(9'd9, "R5 slot2"); rb(9'd0, "R5 slot3");
        @(negedge wclk); wr_en = 1'b1; din = 9'h1FF;
        repeat (3) @(negedge wclk);
        wr_en = 1'b0;
        rb_all(5, 9, "R10 offsets untouched");

        // parallel strap, default 1023
        do_mrst(1'b1);
        check("R1 dout after parallel reset", int'(dout), 0);
        rb_all(1023, 1023, "R1 parallel default");

        // partial reset in the middle of a parallel sequence
        par_write(9'h033);
        do_prst();
        par_write(9'h0AB); par_write(9'h1F5);
        par_write(9'h010); par_write(9'h002);
        rb_all(2731, 1040, "R4 parallel write order");
        flags(2730, 0, 2731, 1040);
        flags(2731, 0, 2731, 1040);
        flags(3056, 0, 2731, 1040);
        flags(3057, 0, 2731, 1040);

        // serial stream in parallel mode is ignored
        ser_load(24'hFFFFFF, 24);
        rb_all(2731, 1040, "R9 serial in parallel mode");

        repeat (4) @(negedge rclk);
        if (exp_q.size() != 0) check("R5 pending readbacks", exp_q.size(), 0);
        summary();
    end

endmodule